// File: doc/BRIEF.md
# Home-Node Shared Data Cache

This block is a small, fully associative store of line data kept beside the coherence controller of a home node. It only ever holds lines that belong to this node and whose copy in main memory is valid, so every entry is marked either Uncached (no processor caches it) or Shared (read-only copies exist elsewhere). When an incoming miss is looked up here and hits, the line can go straight back to the requester and the read already launched to main memory can be dropped.

Entries are created and removed by coherence events rather than by processor traffic. Three event kinds create an entry: a load miss served from memory while the directory entry was found in a fast directory level, a write-back from the single owner, and a cache-to-cache transfer that answered a load miss. One invalidation input covers both a miss that hands out an exclusive copy and the eviction of the matching directory entry. When full, the least recently used entry is dropped without any write, since memory is valid. A hit on an Uncached entry also tells the controller the directory state, as no processor caches that line.

Top module: `home_sdc`

## Requirements
- R1: After reset no entry is valid and `rsp_valid` is low; a lookup issued then reports a miss.
- R2: A lookup on `lk_valid` yields `rsp_valid` exactly one cycle later with hit flag, line data and state; on a miss the data is zero and the state is 2'b00. A lookup sees the contents before any event of the same cycle.
- R3: State codes are 2'b00 absent, 2'b01 Uncached, 2'b10 Shared. A fill of kind 2'b00 (load served by memory) allocates the line as Shared only when `fill_dir_hit` is high; with `fill_dir_hit` low it changes nothing.
- R4: A fill of kind 2'b01 (owner write-back) allocates the line as Uncached with the supplied data.
- R5: A fill of kind 2'b10 (cache-to-cache load completion) allocates the line as Shared.
- R6: A fill of kind 2'b11 is ignored.
- R7: `rsp_dir_known` is high exactly when the lookup hit an Uncached entry.
- R8: `mem_rd_cancel` is high exactly when the lookup hit.
- R9: An invalidation removes the entry holding `inv_addr`; an invalidation of an absent address has no effect; a fill and an invalidation of the same address in one cycle leave the line absent.
- R10: A fill of an address already held rewrites that entry's data and state in place and never creates a second entry.
- R11: A new line takes a free entry when one exists; otherwise it silently replaces the least recently used entry, where fills and lookup hits both count as uses (a fill wins when both occur in one cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Line address to look up |
| fill_valid | input | 1 | Allocation event |
| fill_kind | input | 2 | Event kind: 00 load via memory, 01 owner write-back, 10 cache-to-cache load, 11 none |
| fill_dir_hit | input | 1 | Directory entry was found in a fast level (kind 00 only) |
| fill_addr | input | ADDR_W | Line address to allocate |
| fill_data | input | DATA_W | Line data |
| inv_valid | input | 1 | Invalidation event (exclusive grant or directory eviction) |
| inv_addr | input | ADDR_W | Line address to remove |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_data | output | DATA_W | Line data on hit, zero on miss |
| rsp_state | output | 2 | Line state code |
| rsp_dir_known | output | 1 | Hit on an Uncached line: directory state supplied |
| mem_rd_cancel | output | 1 | Drop the parallel main-memory read |

## Verification
The hardest case to reach from the ports is the replacement choice once the store is full, because the order of use is only visible through which line later goes missing. The stimulus fills every entry, reorders recency with lookup hits, adds one more line, and then probes each address so that exactly the expected oldest one misses; it then frees a slot by invalidation to show a free entry is taken before any victim, and stacks a fill and an invalidation of one address in the same cycle.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   typedef enum logic [1:0] {
      ST_NONE = 2'b00,
      ST_UNC  = 2'b01,
      ST_SHR  = 2'b10
   } line_st_e;

   typedef enum logic [1:0] {
      FK_LOADMEM = 2'b00,
      FK_OWNERWB = 2'b01,
      FK_C2C     = 2'b10,
      FK_RSVD    = 2'b11
   } fill_kind_e;
endpackage

// File: rtl/sdc_pick.sv
module sdc_pick #(
   parameter int N  = 8,
   localparam int IW = (N < 2) ? 1 : $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/sdc_lru.sv
module sdc_lru #(
   parameter int N  = 8,
   localparam int IW = (N < 2) ? 1 : $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch_en,
   input  logic [IW-1:0] touch_idx,
   output logic [IW-1:0] victim_idx
);
   localparam logic [IW-1:0] OLDEST = IW'(N - 1);

   logic [IW-1:0] rank_q [N];
   logic [N-1:0]  old_vec;
   logic [IW-1:0] touch_rank;

   assign touch_rank = rank_q[touch_idx];

   always_ff @(posedge clk) begin
      for (int i = 0; i < N; i++) begin
         if (!rst_n) begin
            rank_q[i] <= IW'(i);
         end else if (touch_en) begin
            if (touch_idx == IW'(i))
               rank_q[i] <= '0;
            else if (rank_q[i] < touch_rank)
               rank_q[i] <= rank_q[i] + 1'b1;
         end
      end
   end

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_old
         assign old_vec[g] = (rank_q[g] == OLDEST);
      end
   endgenerate

   always_comb begin
      victim_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (old_vec[i]) victim_idx = IW'(i);
      end
   end

   // R11
   one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(old_vec));
endmodule

// File: rtl/home_sdc.sv
module home_sdc
   import sdc_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int ADDR_W  = 20,
   parameter int DATA_W  = 64,
   localparam int IW = (ENTRIES < 2) ? 1 : $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic              fill_valid,
   input  logic [1:0]        fill_kind,
   input  logic              fill_dir_hit,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              inv_valid,
   input  logic [ADDR_W-1:0] inv_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [DATA_W-1:0] rsp_data,
   output logic [1:0]        rsp_state,
   output logic              rsp_dir_known,
   output logic              mem_rd_cancel
);
   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("home_sdc: ENTRIES must be at least 2");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("home_sdc: widths must be positive");
      end
   endgenerate

   logic              vld_q [ENTRIES];
   logic [ADDR_W-1:0] tag_q [ENTRIES];
   logic [DATA_W-1:0] dat_q [ENTRIES];
   logic [1:0]        st_q  [ENTRIES];

   logic [ENTRIES-1:0] lk_match, fl_match, inv_match, free_vec;
   logic               lk_any, fl_any, free_any;
   logic [IW-1:0]      lk_idx, fl_idx, free_idx, victim_idx, tgt_idx;
   logic               kind_ok, fill_ok, same_inv;
   logic [1:0]         fill_state;
   logic               touch_en;
   logic [IW-1:0]      touch_idx;

   genvar g;
   generate
      for (g = 0; g < ENTRIES; g++) begin : g_cmp
         assign lk_match[g]  = vld_q[g] && (tag_q[g] == lk_addr);
         assign fl_match[g]  = vld_q[g] && (tag_q[g] == fill_addr);
         assign inv_match[g] = vld_q[g] && (tag_q[g] == inv_addr);
         assign free_vec[g]  = !vld_q[g];
      end
   endgenerate

   sdc_pick #(.N(ENTRIES)) u_pick_lk   (.req(lk_match), .any(lk_any),   .idx(lk_idx));
   sdc_pick #(.N(ENTRIES)) u_pick_fl   (.req(fl_match), .any(fl_any),   .idx(fl_idx));
   sdc_pick #(.N(ENTRIES)) u_pick_free (.req(free_vec), .any(free_any), .idx(free_idx));

   always_comb begin
      case (fill_kind)
         FK_LOADMEM: kind_ok = fill_dir_hit;
         FK_OWNERWB: kind_ok = 1'b1;
         FK_C2C:     kind_ok = 1'b1;
         default:    kind_ok = 1'b0;
      endcase
   end

   assign same_inv   = inv_valid && (inv_addr == fill_addr);
   assign fill_ok    = fill_valid && kind_ok && !same_inv;
   assign fill_state = (fill_kind == FK_OWNERWB) ? ST_UNC : ST_SHR;
   assign tgt_idx    = fl_any ? fl_idx : (free_any ? free_idx : victim_idx);

   assign touch_en  = fill_ok || (lk_valid && lk_any);
   assign touch_idx = fill_ok ? tgt_idx : lk_idx;

   sdc_lru #(.N(ENTRIES)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch_en   (touch_en),
      .touch_idx  (touch_idx),
      .victim_idx (victim_idx)
   );

   always_ff @(posedge clk) begin
      for (int i = 0; i < ENTRIES; i++) begin
         if (!rst_n) begin
            vld_q[i] <= 1'b0;
            tag_q[i] <= '0;
            dat_q[i] <= '0;
            st_q[i]  <= ST_NONE;
         end else if (fill_ok && (tgt_idx == IW'(i))) begin
            vld_q[i] <= 1'b1;
            tag_q[i] <= fill_addr;
            dat_q[i] <= fill_data;
            st_q[i]  <= fill_state;
         end else if (inv_valid && inv_match[i]) begin
            vld_q[i] <= 1'b0;
            st_q[i]  <= ST_NONE;
         end
      end
   end

   logic hit_now;
   assign hit_now = lk_valid && lk_any;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_hit       <= 1'b0;
         rsp_data      <= '0;
         rsp_state     <= ST_NONE;
         rsp_dir_known <= 1'b0;
         mem_rd_cancel <= 1'b0;
      end else begin
         rsp_valid     <= lk_valid;
         rsp_hit       <= hit_now;
         rsp_data      <= hit_now ? dat_q[lk_idx] : '0;
         rsp_state     <= hit_now ? st_q[lk_idx] : ST_NONE;
         rsp_dir_known <= hit_now && (st_q[lk_idx] == ST_UNC);
         mem_rd_cancel <= hit_now;
      end
   end

   // R2
   rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);
   // R2
   hit_has_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_valid && rsp_state != ST_NONE));
   // R7
   dir_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_dir_known |-> (rsp_hit && rsp_state == ST_UNC));
   // R8
   cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (mem_rd_cancel == rsp_hit));
   // R10
   no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fl_match));
endmodule

// File: tb/home_sdc_tb.sv
`timescale 1ns/1ps
module home_sdc_tb;
   localparam int N  = 4;
   localparam int AW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_valid = 1'b0;
   logic [AW-1:0] lk_addr = '0;
   logic          fill_valid = 1'b0;
   logic [1:0]    fill_kind = '0;
   logic          fill_dir_hit = 1'b0;
   logic [AW-1:0] fill_addr = '0;
   logic [DW-1:0] fill_data = '0;
   logic          inv_valid = 1'b0;
   logic [AW-1:0] inv_addr = '0;
   logic          rsp_valid, rsp_hit, rsp_dir_known, mem_rd_cancel;
   logic [DW-1:0] rsp_data;
   logic [1:0]    rsp_state;

   always #2.5 clk = ~clk;

   home_sdc #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_addr(lk_addr),
      .fill_valid(fill_valid), .fill_kind(fill_kind), .fill_dir_hit(fill_dir_hit),
      .fill_addr(fill_addr), .fill_data(fill_data),
      .inv_valid(inv_valid), .inv_addr(inv_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
      .rsp_state(rsp_state), .rsp_dir_known(rsp_dir_known), .mem_rd_cancel(mem_rd_cancel)
   );

   typedef struct {
      logic          hit;
      logic [1:0]    st;
      logic [DW-1:0] data;
      string         req;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;

   localparam logic [1:0] S_NONE = 2'b00, S_UNC = 2'b01, S_SHR = 2'b10;
   localparam logic [1:0] K_MEM = 2'b00, K_WB = 2'b01, K_C2C = 2'b10, K_RSV = 2'b11;

   function automatic logic [DW-1:0] dval(input logic [AW-1:0] a, input logic [15:0] salt);
      return {salt, a};
   endfunction

   task automatic look(input logic [AW-1:0] a, input logic hit, input logic [1:0] st,
                       input logic [DW-1:0] d, input string req);
      exp_t e;
      @(negedge clk);
      lk_valid = 1'b1;
      lk_addr  = a;
      e.hit = hit; e.st = st; e.data = hit ? d : '0; e.req = req;
      exp_q.push_back(e);
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic fill(input logic [1:0] k, input logic dh, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
      @(negedge clk);
      fill_valid = 1'b1; fill_kind = k; fill_dir_hit = dh; fill_addr = a; fill_data = d;
      @(negedge clk);
      fill_valid = 1'b0; fill_dir_hit = 1'b0;
   endtask

   task automatic inval(input logic [AW-1:0] a);
      @(negedge clk);
      inv_valid = 1'b1; inv_addr = a;
      @(negedge clk);
      inv_valid = 1'b0;
   endtask

   task automatic fill_and_inv(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      fill_valid = 1'b1; fill_kind = K_C2C; fill_addr = a; fill_data = d;
      inv_valid = 1'b1; inv_addr = a;
      @(negedge clk);
      fill_valid = 1'b0; inv_valid = 1'b0;
   endtask

   // monitor: compare each response against the oldest expectation
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R2: unexpected response hit=%0b", rsp_hit);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (rsp_hit !== e.hit || rsp_state !== e.st || rsp_data !== e.data ||
                rsp_dir_known !== (e.hit && e.st == S_UNC) || mem_rd_cancel !== e.hit) begin
               n_bad++;
               $display("FAIL %s: got hit=%0b st=%0d data=%h dk=%0b cancel=%0b, exp hit=%0b st=%0d data=%h dk=%0b cancel=%0b",
                        e.req, rsp_hit, rsp_state, rsp_data, rsp_dir_known, mem_rd_cancel,
                        e.hit, e.st, e.data, (e.hit && e.st == S_UNC), e.hit);
            end
         end
      end
   end

   localparam logic [AW-1:0] A = 16'h0100, B = 16'h0200, C = 16'h0300, D = 16'h0400,
                             E = 16'h0500, F = 16'h0600, G = 16'h0700;

   logic done = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;
      if (rsp_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: rsp_valid=%0b in reset, exp 0", rsp_valid);
      end
      rst_n = 1'b1;
      look(A, 0, S_NONE, '0, "R1");
      // R3: load via memory without fast directory hit is not kept
      fill(K_MEM, 0, A, dval(A, 16'h1111));
      look(A, 0, S_NONE, '0, "R3");
      // R3, R8: with directory hit, allocated Shared and memory read cancelled
      fill(K_MEM, 1, A, dval(A, 16'h1111));
      look(A, 1, S_SHR, dval(A, 16'h1111), "R3");
      // R4, R7: owner write-back gives Uncached and directory state known
      fill(K_WB, 0, B, dval(B, 16'h2222));
      look(B, 1, S_UNC, dval(B, 16'h2222), "R4");
      // R5
      fill(K_C2C, 0, C, dval(C, 16'h3333));
      look(C, 1, S_SHR, dval(C, 16'h3333), "R5");
      // R6: reserved kind ignored
      fill(K_RSV, 1, D, dval(D, 16'h4444));
      look(D, 0, S_NONE, '0, "R6");
      fill(K_WB, 0, D, dval(D, 16'h4444));
      look(D, 1, S_UNC, dval(D, 16'h4444), "R7");
      // recency now D,C,B,A; touching A leaves B oldest
      look(A, 1, S_SHR, dval(A, 16'h1111), "R8");
      // R11: fifth line silently replaces B
      fill(K_C2C, 0, E, dval(E, 16'h5555));
      look(B, 0, S_NONE, '0, "R11");
      look(E, 1, S_SHR, dval(E, 16'h5555), "R11");
      look(A, 1, S_SHR, dval(A, 16'h1111), "R11");
      look(C, 1, S_SHR, dval(C, 16'h3333), "R11");
      look(D, 1, S_UNC, dval(D, 16'h4444), "R11");
      // R9: invalidation frees A
      inval(A);
      look(A, 0, S_NONE, '0, "R9");
      // R11: freed slot is used before any victim
      fill(K_WB, 0, F, dval(F, 16'h6666));
      look(C, 1, S_SHR, dval(C, 16'h3333), "R11");
      look(D, 1, S_UNC, dval(D, 16'h4444), "R11");
      look(E, 1, S_SHR, dval(E, 16'h5555), "R11");
      look(F, 1, S_UNC, dval(F, 16'h6666), "R11");
      // R10: refill of a held line rewrites in place
      fill(K_WB, 0, C, dval(C, 16'hCCCC));
      look(C, 1, S_UNC, dval(C, 16'hCCCC), "R10");
      look(E, 1, S_SHR, dval(E, 16'h5555), "R10");
      look(D, 1, S_UNC, dval(D, 16'h4444), "R10");
      look(F, 1, S_UNC, dval(F, 16'h6666), "R10");
      // R9: invalidating an absent line changes nothing
      inval(G);
      look(C, 1, S_UNC, dval(C, 16'hCCCC), "R9");
      look(D, 1, S_UNC, dval(D, 16'h4444), "R9");
      look(E, 1, S_SHR, dval(E, 16'h5555), "R9");
      look(F, 1, S_UNC, dval(F, 16'h6666), "R9");
      // R9: same-cycle fill and invalidation of one line leaves it absent
      fill_and_inv(G, dval(G, 16'h7777));
      look(G, 0, S_NONE, '0, "R9");
      look(C, 1, S_UNC, dval(C, 16'hCCCC), "R9");
      repeat (3) @(negedge clk);
      n_chk++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R2: %0d responses missing, exp 0", exp_q.size());
      end
      done = 1'b1;
   end

   initial begin : watchdog
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL R2: watchdog expired, got hang, exp completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule